// File: doc/BRIEF.md
# Floating-point register block-transfer sequencer

This block moves a contiguous group of floating-point registers between a register file and a memory port that carries one 32-bit word per beat. Each command names a direction, a precision, the registers (as a bit mask), an addressing mode, a base address and whether the base is written back. After it accepts a command, the block checks the register list. It then steps through the words in ascending address order and issues one memory beat per word. On the cycle after the last beat it reports the new base value.

The register file is seen as a bank of 32-bit single halves, so `rf_addr` always names a single half. A double register d_k is the pair of halves 2k (lower address) and 2k+1 (higher address). In unformatted mode the register list uses double registers, and the transfer carries one extra pad word after the data. The pad word is written to memory as zero on a store and discarded on a load. The base always moves by the full odd word count.

A command arrives as a one-cycle `cmd_valid` while `cmd_ready` is high. A rejected command produces an `illegal` pulse instead of any memory traffic. The memory side holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` until `mem_ready` accepts the beat.

Top module: `fpxfer_seq`

## Requirements
- R1: With precision code 2'b00 (single), each set bit k of `cmd_list` moves exactly one word, to or from single register k. Beat i addresses start+4*i and uses register first+i, where first is the lowest set bit.
- R2: With precision code 2'b01 (double), bit k of `cmd_list` names d_k, and each double moves two words. Half 2k is at the lower address and half 2k+1 at the next word.
- R3: With precision code 2'b10 (unformatted), a list of n doubles moves 2n+1 words. The first 2n words follow R2. The final word is a pad word: on a store it is written as zero, and on a load it asserts no `rf_we`.
- R4: With `cmd_wb`=1, `base_out` on the done cycle equals base+4*W in increment-after mode (`cmd_dec`=0) and base-4*W in decrement-before mode (`cmd_dec`=1). W is the word count of R1 to R3, so it is 2n+1 in unformatted mode.
- R5: With `cmd_wb`=0, `base_out` on the done cycle equals `cmd_base`.
- R6: A `cmd_list` that is empty or whose set bits are not one contiguous run is rejected. `illegal` pulses in the cycle after acceptance, and no memory beat and no register write follow.
- R7: In double or unformatted mode, any set bit at position 16 or above (past d15) is rejected as in R6. Precision code 2'b11 is also rejected as in R6.
- R8: In decrement-before mode the first address is base-4*W. Every later beat is 4 bytes above the previous one.
- R9: `done` pulses for exactly one cycle, in the cycle after the memory accepts the last beat. `cmd_ready` is high whenever no transfer is running, and low while `mem_req` is high.
- R10: While `mem_req` is high and `mem_ready` is low, the request, address and write flag hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| cmd_prec | input | 2 | 00 single, 01 double, 10 unformatted, 11 rejected |
| cmd_list | input | NREG | Register mask, one bit per register of the chosen bank |
| cmd_dec | input | 1 | 1 = decrement-before, 0 = increment-after |
| cmd_wb | input | 1 | Write back the updated base |
| cmd_base | input | AW | Base byte address |
| rf_addr | output | log2(NREG) | Single-half index for register file access |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | DW | Register file write data |
| rf_rdata | input | DW | Register file read data for `rf_addr`, same cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | DW | Write data of the beat |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| done | output | 1 | One-cycle pulse after the last beat |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| base_out | output | AW | Updated base value, valid with `done` |

## Verification
A wrong word counter appears at the ports as an extra or missing beat and as a `done` pulse one beat early or late. The reference queue reports this on the very beat it happens. A wrong address register or start value shows as a mismatched `mem_addr` on the first affected beat. A wrong register index shows as wrong store data or a write to the wrong `rf_addr` in the same cycle. A lost pad flag shows as a non-zero pad word or a stray `rf_we` on the final beat, and a wrong result register shows only in `base_out` on the done cycle.

// File: rtl/fpxfer_pkg.sv
package fpxfer_pkg;

    typedef enum logic [1:0] {
        PREC_SGL = 2'b00,
        PREC_DBL = 2'b01,
        PREC_UNF = 2'b10,
        PREC_BAD = 2'b11
    } prec_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_XFER = 1'b1
    } phase_e;

endpackage

// File: rtl/fpxfer_plan.sv
module fpxfer_plan
    import fpxfer_pkg::*;
#(
    parameter  int NREG = 32,
    parameter  int AW   = 32,
    localparam int RIW  = $clog2(NREG),
    localparam int CW   = $clog2(NREG + 2)
) (
    input  logic [1:0]      prec,
    input  logic [NREG-1:0] list,
    input  logic            dec,
    input  logic            wb,
    input  logic [AW-1:0]   base,
    output logic            ok,
    output logic [RIW-1:0]  first_s,
    output logic [CW-1:0]   words,
    output logic [AW-1:0]   start,
    output logic [AW-1:0]   final_base
);
    localparam int NDBL = NREG / 2;

    logic [RIW-1:0] lowest;
    logic           found;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  runs;
    logic           prev;
    logic [AW-1:0]  bytes;
    logic           upper_set;

    // Scan the mask: lowest set bit, population and number of separate runs.
    always_comb begin
        lowest = '0;
        found  = 1'b0;
        cnt    = '0;
        runs   = '0;
        prev   = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            if (list[k]) begin
                cnt = cnt + CW'(1);
                if (!found) begin
                    lowest = RIW'(k);
                    found  = 1'b1;
                end
                if (!prev) begin
                    runs = runs + CW'(1);
                end
            end
            prev = list[k];
        end
    end

    assign upper_set = |list[NREG-1:NDBL];

    always_comb begin
        ok = found && (runs == CW'(1)) && (prec != PREC_BAD) &&
             ((prec == PREC_SGL) || !upper_set);
        case (prec)
            PREC_DBL: words = {cnt[CW-2:0], 1'b0};
            PREC_UNF: words = {cnt[CW-2:0], 1'b1};
            default:  words = cnt;
        endcase
        first_s = (prec == PREC_SGL) ? lowest : {lowest[RIW-2:0], 1'b0};
        bytes   = AW'({words, 2'b00});
        start   = dec ? (base - bytes) : base;
        if (!wb) begin
            final_base = base;
        end else if (dec) begin
            final_base = base - bytes;
        end else begin
            final_base = base + bytes;
        end
    end

endmodule

// File: rtl/fpxfer_map.sv
module fpxfer_map
    import fpxfer_pkg::*;
#(
    parameter  int NREG = 32,
    localparam int RIW  = $clog2(NREG),
    localparam int CW   = $clog2(NREG + 2)
) (
    input  logic [RIW-1:0] first_s,
    input  logic [CW-1:0]  idx,
    input  logic [1:0]     prec,
    input  logic [CW-1:0]  words,
    output logic [RIW-1:0] reg_idx,
    output logic           pad
);
    // Word i of the transfer always touches single half first_s + i; the
    // unformatted mode appends one pad word after the data words.
    always_comb begin
        reg_idx = first_s + idx[RIW-1:0];
        pad     = (prec == PREC_UNF) && (idx == words - CW'(1));
    end

endmodule

// File: rtl/fpxfer_seq.sv
module fpxfer_seq
    import fpxfer_pkg::*;
#(
    parameter  int NREG = 32,
    parameter  int AW   = 32,
    parameter  int DW   = 32,
    localparam int RIW  = $clog2(NREG),
    localparam int CW   = $clog2(NREG + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic            cmd_store,
    input  logic [1:0]      cmd_prec,
    input  logic [NREG-1:0] cmd_list,
    input  logic            cmd_dec,
    input  logic            cmd_wb,
    input  logic [AW-1:0]   cmd_base,
    output logic [RIW-1:0]  rf_addr,
    output logic            rf_we,
    output logic [DW-1:0]   rf_wdata,
    input  logic [DW-1:0]   rf_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ready,
    output logic            done,
    output logic            illegal,
    output logic [AW-1:0]   base_out
);
    localparam int NDBL = NREG / 2;

    typedef struct packed {
        phase_e         ph;
        logic           store;
        logic [1:0]     prec;
        logic [RIW-1:0] first_s;
        logic [CW-1:0]  words;
        logic [CW-1:0]  idx;
        logic [AW-1:0]  addr;
        logic [AW-1:0]  nbase;
        logic           done;
        logic           bad;
    } seq_t;

    seq_t seq_d, seq_q;

    logic           plan_ok;
    logic [RIW-1:0] plan_first;
    logic [CW-1:0]  plan_words;
    logic [AW-1:0]  plan_start;
    logic [AW-1:0]  plan_final;
    logic [RIW-1:0] cur_reg;
    logic           cur_pad;
    logic           last;
    logic           beat;

    fpxfer_plan #(.NREG(NREG), .AW(AW)) u_plan (
        .prec       (cmd_prec),
        .list       (cmd_list),
        .dec        (cmd_dec),
        .wb         (cmd_wb),
        .base       (cmd_base),
        .ok         (plan_ok),
        .first_s    (plan_first),
        .words      (plan_words),
        .start      (plan_start),
        .final_base (plan_final)
    );

    fpxfer_map #(.NREG(NREG)) u_map (
        .first_s (seq_q.first_s),
        .idx     (seq_q.idx),
        .prec    (seq_q.prec),
        .words   (seq_q.words),
        .reg_idx (cur_reg),
        .pad     (cur_pad)
    );

    assign last = (seq_q.idx == seq_q.words - CW'(1));
    assign beat = (seq_q.ph == PH_XFER) && mem_ready;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.bad  = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (!plan_ok) begin
                        seq_d.bad = 1'b1;
                    end else begin
                        seq_d.ph      = PH_XFER;
                        seq_d.store   = cmd_store;
                        seq_d.prec    = cmd_prec;
                        seq_d.first_s = plan_first;
                        seq_d.words   = plan_words;
                        seq_d.idx     = '0;
                        seq_d.addr    = plan_start;
                        seq_d.nbase   = plan_final;
                    end
                end
            end
            default: begin
                if (mem_ready) begin
                    if (last) begin
                        seq_d.ph   = PH_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.idx  = seq_q.idx + CW'(1);
                        seq_d.addr = seq_q.addr + AW'(4);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready = (seq_q.ph == PH_IDLE);
    assign mem_req   = (seq_q.ph == PH_XFER);
    assign mem_we    = mem_req && seq_q.store;
    assign mem_addr  = seq_q.addr;
    assign mem_wdata = cur_pad ? '0 : rf_rdata;
    assign rf_addr   = cur_reg;
    assign rf_we     = beat && !seq_q.store && !cur_pad;
    assign rf_wdata  = mem_rdata;
    assign done      = seq_q.done;
    assign illegal   = seq_q.bad;
    assign base_out  = seq_q.nbase;

    // R10: a stalled beat keeps its request, address and direction
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: consecutive beats of one transfer climb by one word
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !last) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(4)));

    // R6: a rejection pulse comes with no memory or register activity
    p_bad_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !rf_we));

    // R7: a double-bank list reaching past the bank end is rejected next cycle
    p_range_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_prec != PREC_SGL && (|cmd_list[NREG-1:NDBL]))
        |=> illegal);

    // R9: done follows an accepted beat and never coincides with a rejection
    p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_req && mem_ready) && cmd_ready));

    p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal}));

    // R3: the pad word never reaches the register file and is stored as zero
    p_pad_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cur_pad) |-> (!rf_we && (!mem_we || mem_wdata == '0)));

endmodule

// File: tb/fpxfer_seq_bench.sv
module fpxfer_seq_bench;
    localparam int NREG = 32;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmd_valid;
    logic            cmd_ready;
    logic            cmd_store;
    logic [1:0]      cmd_prec;
    logic [NREG-1:0] cmd_list;
    logic            cmd_dec;
    logic            cmd_wb;
    logic [AW-1:0]   cmd_base;
    logic [4:0]      rf_addr;
    logic            rf_we;
    logic [DW-1:0]   rf_wdata;
    logic [DW-1:0]   rf_rdata;
    logic            mem_req;
    logic            mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata;
    logic            mem_ready;
    logic            done;
    logic            illegal;
    logic [AW-1:0]   base_out;

    always #4 clk = ~clk;

    fpxfer_seq #(.NREG(NREG), .AW(AW), .DW(DW)) u_fpxfer_seq (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_store, .cmd_prec, .cmd_list,
        .cmd_dec, .cmd_wb, .cmd_base, .rf_addr, .rf_we, .rf_wdata, .rf_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ready,
        .done, .illegal, .base_out
    );

    // Register file and memory environment
    logic [31:0] rf [NREG];
    assign rf_rdata  = rf[rf_addr];
    assign mem_rdata = mem_addr ^ RD_KEY;
    always @(posedge clk) if (rf_we) rf[rf_addr] <= rf_wdata;

    int   cyc = 0;
    logic rdy_q = 1'b0;
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        rdy_q <= ((cyc % 5) != 2) && ((cyc % 7) != 3);
    end
    assign mem_ready = rdy_q;

    // Reference queues of expected beats
    logic [31:0] ex_addr [$];
    int          ex_reg  [$];
    logic        ex_store = 1'b0;
    string       cur_tag  = "R1";
    int          checks   = 0;
    int          fails    = 0;
    logic        run_chk  = 1'b0;
    logic        pend_done = 1'b0;
    logic        hold_v   = 1'b0;
    logic [31:0] hold_a   = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run_chk) begin
            chk(done == pend_done, "R9", "done timing", 32'(done), 32'(pend_done));
            pend_done = 1'b0;
            if (hold_v) begin
                chk(mem_req && mem_addr == hold_a, "R10", "stalled beat held", mem_addr, hold_a);
            end
            hold_v = mem_req && !mem_ready;
            hold_a = mem_addr;
            if (mem_req) chk(!cmd_ready, "R9", "ready low while busy", 32'(cmd_ready), 32'd0);
            if (mem_req && mem_ready) begin
                if (ex_addr.size() == 0) begin
                    chk(1'b0, "R6", "unexpected beat", mem_addr, 32'd0);
                end else begin
                    logic [31:0] a;
                    int r;
                    a = ex_addr.pop_front();
                    r = ex_reg.pop_front();
                    chk(mem_addr == a, (cur_tag == "R2") ? "R8" : cur_tag, "beat address", mem_addr, a);
                    chk(mem_we == ex_store, cur_tag, "beat direction", 32'(mem_we), 32'(ex_store));
                    if (ex_store) begin
                        if (r < 0) chk(mem_wdata == 32'd0, "R3", "pad store data", mem_wdata, 32'd0);
                        else chk(mem_wdata == rf[r], cur_tag, "store data", mem_wdata, rf[r]);
                    end else begin
                        if (r < 0) chk(!rf_we, "R3", "pad load writes no register", 32'(rf_we), 32'd0);
                        else begin
                            chk(rf_we && rf_addr == 5'(r), cur_tag, "load register", 32'(rf_addr), 32'(r));
                            chk(rf_wdata == (a ^ RD_KEY), cur_tag, "load data", rf_wdata, a ^ RD_KEY);
                        end
                    end
                    if (ex_addr.size() == 0) pend_done = 1'b1;
                end
            end
        end
    end

    task automatic run(input string tag, input string btag, input bit st,
                       input logic [1:0] pr, input logic [31:0] lst, input bit dec,
                       input bit wb, input logic [31:0] base, input bit expect_bad);
        int first, cnt, words, t;
        logic [31:0] start, nb;
        first = -1;
        cnt = 0;
        for (int k = 0; k < NREG; k++) begin
            if (lst[k]) begin
                cnt++;
                if (first < 0) first = k;
            end
        end
        words = (pr == 2'b00) ? cnt : (pr == 2'b01) ? 2 * cnt : 2 * cnt + 1;
        start = dec ? base - 32'(4 * words) : base;
        nb    = !wb ? base : dec ? base - 32'(4 * words) : base + 32'(4 * words);
        if (!expect_bad) begin
            for (int i = 0; i < words; i++) begin
                ex_addr.push_back(start + 32'(4 * i));
                if (pr == 2'b10 && i == words - 1) ex_reg.push_back(-1);
                else ex_reg.push_back((pr == 2'b00) ? first + i : 2 * first + i);
            end
        end
        ex_store = st;
        cur_tag  = tag;
        @(negedge clk);
        chk(cmd_ready, "R9", "ready before command", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1; cmd_store = st; cmd_prec = pr; cmd_list = lst;
        cmd_dec = dec; cmd_wb = wb; cmd_base = base;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (expect_bad) begin
            chk(illegal, tag, "rejection pulse", 32'(illegal), 32'd1);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!mem_req && !illegal, tag, "no transfer after rejection", 32'(mem_req), 32'd0);
            end
        end else begin
            t = 0;
            while (!done && t < 2000) begin
                @(negedge clk);
                t++;
            end
            chk(done, "R9", "transfer finished", 32'(done), 32'd1);
            chk(base_out == nb, btag, "updated base", base_out, nb);
            chk(ex_addr.size() == 0, tag, "all words moved", 32'(ex_addr.size()), 32'd0);
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) rf[k] = 32'h1000_0000 + 32'(k * 32'h111);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0; cmd_prec = 2'b00;
        cmd_list = '0; cmd_dec = 1'b0; cmd_wb = 1'b0; cmd_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !mem_req && !done && !illegal, "R9", "reset state",
            {28'd0, cmd_ready, mem_req, done, illegal}, 32'h8);
        run_chk = 1'b1;
        // R1 + R5: single store s1..s5, no writeback
        run("R1", "R5", 1'b1, 2'b00, 32'h0000_003E, 1'b0, 1'b0, 32'h0000_0100, 1'b0);
        // R1 + R4: single load of s31 alone, writeback
        run("R1", "R4", 1'b0, 2'b00, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_0200, 1'b0);
        // R2 + R8 + R4: double store d3..d6, decrement-before
        run("R2", "R4", 1'b1, 2'b01, 32'h0000_0078, 1'b1, 1'b1, 32'h0000_2000, 1'b0);
        // R3 + R4: unformatted store d0..d3, decrement-before, odd word count
        run("R3", "R4", 1'b1, 2'b10, 32'h0000_000F, 1'b1, 1'b1, 32'h0000_3000, 1'b0);
        // R3 + R4: matching unformatted load, increment-after
        run("R3", "R4", 1'b0, 2'b10, 32'h0000_000F, 1'b0, 1'b1, 32'h0000_2FDC, 1'b0);
        // R2 + R5: double load d15, last double, no writeback
        run("R2", "R5", 1'b0, 2'b01, 32'h0000_8000, 1'b0, 1'b0, 32'h0000_0400, 1'b0);
        // R1 + R4: whole single bank load
        run("R1", "R4", 1'b0, 2'b00, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0000_4000, 1'b0);
        // R1 + R8: single store decrement-before without writeback
        run("R8", "R5", 1'b1, 2'b00, 32'h0000_0700, 1'b1, 1'b0, 32'h0000_5000, 1'b0);
        // R6: non-contiguous double list d0,d2,d3
        run("R6", "R6", 1'b0, 2'b01, 32'h0000_000D, 1'b0, 1'b1, 32'h0000_0600, 1'b1);
        // R6: empty list
        run("R6", "R6", 1'b1, 2'b00, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0600, 1'b1);
        // R7: double list running past d15
        run("R7", "R7", 1'b1, 2'b01, 32'h0001_8000, 1'b0, 1'b0, 32'h0000_0700, 1'b1);
        // R7: reserved precision code
        run("R7", "R7", 1'b0, 2'b11, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_0800, 1'b1);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule